// File: doc/BRIEF.md
# Receive Character Queue with Idle Watchdog and Flow Control

This block is the receive-side buffer of one serial channel. A deserializer hands it complete characters, each with three error flags: framing, parity and break. The block queues them in an eight-entry first-in first-out store and shows the CPU the oldest character and its status. A single holding stage in front of the store keeps one more character while the store is full. A character that arrives while both the store and the holding stage are full is dropped, and a sticky overrun flag is set.

The receive interrupt has two sources. The first is a fill threshold chosen from a non-linear set. The second is a watchdog: it fires when data has waited unread for 64 receive bit times. A request-to-send output follows a software request bit. When flow control is on, the block withdraws the output on its own when a new start bit is seen while the store is full, and restores it once a slot frees.

Two finite-state machines control the behaviour. The watchdog machine has the states WD_IDLE, WD_COUNT and WD_FIRED:
- WD_IDLE moves to WD_COUNT when the watchdog is enabled and the store holds data.
- WD_COUNT moves to WD_FIRED on the 64th idle bit tick.
- WD_COUNT moves back to WD_IDLE when the watchdog is disabled or the store empties.
- WD_FIRED moves to WD_IDLE on a read or when the watchdog is disabled.

The flow machine has the states RTS_OFF, RTS_ON and RTS_HELD:
- RTS_OFF moves to RTS_ON when the request bit is set.
- RTS_ON moves to RTS_HELD on a start strobe while the store is full and flow control is enabled.
- RTS_HELD moves to RTS_ON when the store is no longer full, or when flow control is switched off.
- RTS_ON and RTS_HELD both move to RTS_OFF when the request bit clears.

Top module: `rx_fifo_wdog`

## Requirements
- R1: After reset the store is empty (`rd_avail`=0, `full`=0), `rx_irq`=0, `rts_out`=0, `overrun`=0 and all shown flags are 0.
- R2: Characters leave in arrival order. `rd_data` shows the oldest one, a `rd_pop` pulse removes it, and a `rd_pop` on an empty store changes nothing.
- R3: The fill interrupt is raised when the stored count reaches a threshold set by `cfg_level`: 0 gives 1 or more, 1 gives 3 or more, 2 gives 6 or more, 3 gives exactly 8.
- R4: With `cfg_wdog_en`=1 and data stored, `rx_irq` rises in the cycle after the 64th `bit_tick` that follows the last write or read. Any write into the store or any read restarts this count.
- R5: A read clears a fired watchdog interrupt. With `cfg_wdog_en`=0 the watchdog never raises `rx_irq`.
- R6: A character that arrives while the store holds 8 is kept in the holding stage without overrun. It moves into the store when a slot frees, and order is kept.
- R7: `rts_out` follows `rts_req`. With `cfg_rts_flow`=1, a `start_seen` strobe while the store is full drops `rts_out` in the next cycle while `rts_req` stays 1.
- R8: A dropped `rts_out` returns to 1 by itself one cycle after the store stops being full, with no change to `rts_req`.
- R9: A character that arrives while the store is full and the holding stage is occupied is discarded and sets `overrun`. `overrun` stays set until an `err_clear` pulse, and a read does not clear it.
- R10: With `cfg_block_err`=0, `rd_ferr`, `rd_perr` and `rd_brk` show only the flags of the oldest stored character, and they are 0 when the store is empty.
- R11: With `cfg_block_err`=1, the shown flags are the OR of the flags of every character that has been oldest since the last `err_clear`, including the current oldest one. After `err_clear` with an empty store they read 0.
- R12: A read and an arrival in the same cycle, with the store full and the holding stage occupied, lose nothing and do not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | Character-arrival strobe |
| chr_data | input | 8 | Arriving character |
| chr_ferr | input | 1 | Framing error of arriving character |
| chr_perr | input | 1 | Parity error of arriving character |
| chr_brk | input | 1 | Break flag of arriving character |
| start_seen | input | 1 | Valid start bit detected strobe |
| bit_tick | input | 1 | One pulse per receive bit time |
| rd_pop | input | 1 | CPU read of the oldest character |
| err_clear | input | 1 | Reset-error command pulse |
| cfg_level | input | 2 | Fill interrupt threshold code |
| cfg_wdog_en | input | 1 | Watchdog enable |
| cfg_rts_flow | input | 1 | Receiver flow control enable |
| cfg_block_err | input | 1 | 1 = accumulated flags, 0 = per-character flags |
| rts_req | input | 1 | Software request-to-send bit |
| rd_data | output | 8 | Oldest character |
| rd_ferr | output | 1 | Shown framing status |
| rd_perr | output | 1 | Shown parity status |
| rd_brk | output | 1 | Shown break status |
| rd_avail | output | 1 | Store not empty |
| full | output | 1 | Store holds 8 characters |
| overrun | output | 1 | Sticky character-loss flag |
| rx_irq | output | 1 | Receive interrupt |
| rts_out | output | 1 | Request-to-send, 1 = asserted |

## Verification
A CPU read and a character arrival can fall in the same cycle. This matters most when the store is full and the holding stage is occupied, because the freed slot must take the held character while the arriving one takes its place in the holding stage. The bench fills the store and the holding stage, then raises `rd_pop` and `chr_valid` in one cycle. It judges the result by three things: `overrun` stays 0, `full` stays 1, and draining returns every character in order. Reads that fall on a fired watchdog and pops on an empty store are also provoked on purpose.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              brk;
    } rxq_ent_t;

    typedef struct packed {
        logic ferr;
        logic perr;
        logic brk;
    } rxq_flags_t;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        RTS_OFF  = 2'd0,
        RTS_ON   = 2'd1,
        RTS_HELD = 2'd2
    } rts_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  rxq_ent_t                    in_ent,
    input  logic                        pop,
    input  logic                        err_clear,
    input  logic                        block_mode,
    output rxq_ent_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output rxq_flags_t                  view,
    output logic                        push_evt,
    output logic                        pop_evt,
    output logic                        overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_ent_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    rxq_ent_t        hold;
    logic            hold_v;
    rxq_flags_t      acc;
    rxq_flags_t      head_fl;
    logic            nonempty, space, lost;
    rxq_ent_t        wr_ent;

    assign nonempty = (count != '0);
    assign pop_evt  = pop && nonempty;
    assign space    = (count != CW'(DEPTH)) || pop_evt;
    assign push_evt = space && (hold_v || in_valid);
    assign wr_ent   = hold_v ? hold : in_ent;
    assign lost     = in_valid && hold_v && !space;
    assign head     = mem[rd_ptr];
    assign head_fl  = nonempty ? rxq_flags_t'{head.ferr, head.perr, head.brk} : '0;
    assign view     = block_mode ? (acc | head_fl) : head_fl;

    always_ff @(posedge clk) begin
        if (push_evt) mem[wr_ptr] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            hold    <= '0;
            hold_v  <= 1'b0;
            acc     <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_evt) wr_ptr <= wr_ptr + 1'b1;
            if (pop_evt)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_evt) - CW'(pop_evt);
            if (hold_v) begin
                if (space) begin
                    hold_v <= in_valid;
                    if (in_valid) hold <= in_ent;
                end
            end else if (in_valid && !space) begin
                hold_v <= 1'b1;
                hold   <= in_ent;
            end
            acc     <= err_clear ? '0 : (acc | head_fl);
            overrun <= (overrun && !err_clear) || lost;
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_clear) |=> overrun);
    a_r12_no_loss_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && nonempty && !overrun) |=> !overrun || $past(err_clear));
endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog
    import rxq_pkg::*;
#(
    parameter int IDLE_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic has_data,
    input  logic bit_tick,
    input  logic push_evt,
    input  logic pop_evt,
    output logic wd_irq
);
    localparam int TW = $clog2(IDLE_BITS + 1);

    wd_state_e     state, state_n;
    logic [TW-1:0] ticks;
    logic          activity, expire;

    assign activity = push_evt || pop_evt;
    assign expire   = bit_tick && !activity && (ticks == TW'(IDLE_BITS - 1));

    always_comb begin
        state_n = state;
        unique case (state)
            WD_IDLE:  if (enable && has_data) state_n = WD_COUNT;
            WD_COUNT: begin
                if (!enable || !has_data) state_n = WD_IDLE;
                else if (expire)          state_n = WD_FIRED;
            end
            WD_FIRED: if (!enable || pop_evt) state_n = WD_IDLE;
            default:  state_n = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != WD_COUNT || activity) ticks <= '0;
        else if (bit_tick)                           ticks <= ticks + 1'b1;
    end

    always_comb begin
        wd_irq = (state == WD_FIRED);
    end

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && pop_evt) |=> !wd_irq);
    a_r4_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> $past(bit_tick));
    a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !wd_irq);
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic flow_en,
    input  logic is_full,
    input  logic start_seen,
    output logic rts_out
);
    rts_state_e state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            RTS_OFF:  if (req) state_n = RTS_ON;
            RTS_ON: begin
                if (!req)                               state_n = RTS_OFF;
                else if (flow_en && is_full && start_seen) state_n = RTS_HELD;
            end
            RTS_HELD: begin
                if (!req)                     state_n = RTS_OFF;
                else if (!is_full || !flow_en) state_n = RTS_ON;
            end
            default:  state_n = RTS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RTS_OFF;
        else        state <= state_n;
    end

    always_comb begin
        rts_out = (state == RTS_ON);
    end

    a_r7_drop_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_out && req && flow_en && is_full && start_seen) |=> !rts_out);
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTS_HELD && req && !is_full) |=> rts_out);
    a_r7_follow_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rts_out);
endmodule

// File: rtl/rx_fifo_wdog.sv
module rx_fifo_wdog
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int IDLE_BITS = 64,
    parameter int LVL0      = 1,
    parameter int LVL1      = 3,
    parameter int LVL2      = 6,
    parameter int LVL3      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [CHAR_W-1:0] chr_data,
    input  logic              chr_ferr,
    input  logic              chr_perr,
    input  logic              chr_brk,
    input  logic              start_seen,
    input  logic              bit_tick,
    input  logic              rd_pop,
    input  logic              err_clear,
    input  logic [1:0]        cfg_level,
    input  logic              cfg_wdog_en,
    input  logic              cfg_rts_flow,
    input  logic              cfg_block_err,
    input  logic              rts_req,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rd_perr,
    output logic              rd_brk,
    output logic              rd_avail,
    output logic              full,
    output logic              overrun,
    output logic              rx_irq,
    output logic              rts_out
);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_ent_t      in_ent, head;
    rxq_flags_t    view;
    logic [CW-1:0] count, thresh;
    logic          push_evt, pop_evt, wd_irq, lvl_irq;

    assign in_ent = '{data: chr_data, ferr: chr_ferr, perr: chr_perr, brk: chr_brk};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .in_valid(chr_valid), .in_ent(in_ent),
        .pop(rd_pop), .err_clear(err_clear), .block_mode(cfg_block_err),
        .head(head), .count(count), .view(view), .push_evt(push_evt),
        .pop_evt(pop_evt), .overrun(overrun)
    );

    rxq_wdog #(.IDLE_BITS(IDLE_BITS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .enable(cfg_wdog_en), .has_data(rd_avail),
        .bit_tick(bit_tick), .push_evt(push_evt), .pop_evt(pop_evt), .wd_irq(wd_irq)
    );

    rxq_rts u_rts (
        .clk(clk), .rst_n(rst_n), .req(rts_req), .flow_en(cfg_rts_flow),
        .is_full(full), .start_seen(start_seen), .rts_out(rts_out)
    );

    always_comb begin
        unique case (cfg_level)
            2'd0:    thresh = CW'(LVL0);
            2'd1:    thresh = CW'(LVL1);
            2'd2:    thresh = CW'(LVL2);
            default: thresh = CW'(LVL3);
        endcase
    end

    assign lvl_irq  = (count >= thresh);
    assign rx_irq   = lvl_irq || wd_irq;
    assign rd_data  = head.data;
    assign rd_ferr  = view.ferr;
    assign rd_perr  = view.perr;
    assign rd_brk   = view.brk;
    assign rd_avail = (count != '0);
    assign full     = (count == CW'(DEPTH));

    a_r3_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cfg_level == 2'd3) |-> rx_irq);
endmodule

// File: tb/rx_fifo_wdog_tb.sv
module rx_fifo_wdog_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       chr_valid, chr_ferr, chr_perr, chr_brk;
    logic [7:0] chr_data;
    logic       start_seen, bit_tick, rd_pop, err_clear;
    logic [1:0] cfg_level;
    logic       cfg_wdog_en, cfg_rts_flow, cfg_block_err, rts_req;
    logic [7:0] rd_data;
    logic       rd_ferr, rd_perr, rd_brk, rd_avail, full, overrun, rx_irq, rts_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rx_fifo_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_ferr(chr_ferr), .chr_perr(chr_perr), .chr_brk(chr_brk),
        .start_seen(start_seen), .bit_tick(bit_tick), .rd_pop(rd_pop),
        .err_clear(err_clear), .cfg_level(cfg_level), .cfg_wdog_en(cfg_wdog_en),
        .cfg_rts_flow(cfg_rts_flow), .cfg_block_err(cfg_block_err), .rts_req(rts_req),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr), .rd_brk(rd_brk),
        .rd_avail(rd_avail), .full(full), .overrun(overrun), .rx_irq(rx_irq),
        .rts_out(rts_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] fpb);
        chr_valid = 1'b1; chr_data = d;
        {chr_ferr, chr_perr, chr_brk} = fpb;
        @(negedge clk);
        chr_valid = 1'b0; {chr_ferr, chr_perr, chr_brk} = 3'b000;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        check(tag, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic pulse_start();
        start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        chr_valid = 0; chr_data = 0; chr_ferr = 0; chr_perr = 0; chr_brk = 0;
        start_seen = 0; bit_tick = 0; rd_pop = 0; err_clear = 0;
        cfg_level = 2'd0; cfg_wdog_en = 0; cfg_rts_flow = 0; cfg_block_err = 0; rts_req = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset_state();
        check("R1 avail", rd_avail, 0);
        check("R1 full", full, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 rts", rts_out, 0);
        check("R1 overrun", overrun, 0);
        check("R1 flags", {rd_ferr, rd_perr, rd_brk}, 0);
    endtask

    task automatic t_order();
        pop_chk("R2 empty pop data", rd_data);
        check("R2 empty pop avail", rd_avail, 0);
        check("R2 empty pop overrun", overrun, 0);
        push(8'hA1, 3'b000); push(8'hB2, 3'b000); push(8'hC3, 3'b000);
        pop_chk("R2 first", 8'hA1);
        pop_chk("R2 second", 8'hB2);
        pop_chk("R2 third", 8'hC3);
        check("R2 drained", rd_avail, 0);
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        push(8'h44, 3'b000);
        check("R2 after empty pop", rd_data, 8'h44);
        pop_chk("R2 single", 8'h44);
    endtask

    task automatic t_levels();
        int thr [4] = '{1, 3, 6, 8};
        for (int n = 0; n <= 8; n++) begin
            for (int l = 0; l < 4; l++) begin
                cfg_level = 2'(l);
                #0.5;
                check($sformatf("R3 count=%0d level=%0d", n, l), rx_irq, (n >= thr[l]) ? 1 : 0);
            end
            if (n < 8) push(8'(n), 3'b000);
        end
        check("R3 full flag", full, 1);
        for (int n = 0; n < 8; n++) pop_chk("R3 drain", 8'(n));
        cfg_level = 2'd0;
    endtask

    task automatic t_flow_overrun();
        cfg_rts_flow = 1'b1; rts_req = 1'b1;
        cyc(1);
        check("R7 follows req", rts_out, 1);
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i), 3'b000);
        check("R7 still on when full", rts_out, 1);
        pulse_start();
        check("R7 dropped on start", rts_out, 0);
        push(8'h18, 3'b000);
        check("R6 ninth no overrun", overrun, 0);
        check("R6 still full", full, 1);
        pulse_start();
        push(8'h19, 3'b000);
        check("R9 tenth overrun", overrun, 1);
        pop_chk("R6 head after overflow", 8'h10);
        check("R6 hold refills", full, 1);
        check("R8 still held", rts_out, 0);
        check("R9 read keeps overrun", overrun, 1);
        pop_chk("R6 second", 8'h11);
        check("R6 no longer full", full, 0);
        cyc(1);
        check("R8 restored", rts_out, 1);
        for (int i = 2; i <= 8; i++) pop_chk("R6 order incl ninth", 8'h10 + 8'(i));
        check("R9 tenth lost", rd_avail, 0);
        check("R9 sticky", overrun, 1);
        pulse_clear();
        check("R9 cleared", overrun, 0);
        rts_req = 1'b0; cyc(1);
        check("R7 req low", rts_out, 0);
        cfg_rts_flow = 1'b0;
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 9; i++) push(8'h30 + 8'(i), 3'b000);
        check("R12 pre overrun", overrun, 0);
        chr_valid = 1'b1; chr_data = 8'h39; rd_pop = 1'b1;
        @(negedge clk);
        chr_valid = 1'b0; rd_pop = 1'b0;
        check("R12 no overrun", overrun, 0);
        check("R12 still full", full, 1);
        for (int i = 1; i <= 9; i++) pop_chk("R12 order", 8'h30 + 8'(i));
        check("R12 drained", rd_avail, 0);
    endtask

    task automatic t_err_modes();
        cfg_block_err = 1'b0;
        check("R10 empty flags", {rd_ferr, rd_perr, rd_brk}, 0);
        push(8'h01, 3'b100); push(8'h02, 3'b010); push(8'h03, 3'b001);
        check("R10 head ferr", {rd_ferr, rd_perr, rd_brk}, 3'b100);
        pop_chk("R10 pop1", 8'h01);
        check("R10 head perr", {rd_ferr, rd_perr, rd_brk}, 3'b010);
        pop_chk("R10 pop2", 8'h02);
        check("R10 head brk", {rd_ferr, rd_perr, rd_brk}, 3'b001);
        pop_chk("R10 pop3", 8'h03);
        cfg_block_err = 1'b1;
        pulse_clear();
        check("R11 cleared empty", {rd_ferr, rd_perr, rd_brk}, 0);
        push(8'h04, 3'b100); push(8'h05, 3'b010); push(8'h06, 3'b001);
        check("R11 first head", {rd_ferr, rd_perr, rd_brk}, 3'b100);
        pop_chk("R11 pop1", 8'h04);
        check("R11 accum two", {rd_ferr, rd_perr, rd_brk}, 3'b110);
        pop_chk("R11 pop2", 8'h05);
        check("R11 accum three", {rd_ferr, rd_perr, rd_brk}, 3'b111);
        pop_chk("R11 pop3", 8'h06);
        check("R11 kept when empty", {rd_ferr, rd_perr, rd_brk}, 3'b111);
        pulse_clear();
        check("R11 reset-error", {rd_ferr, rd_perr, rd_brk}, 0);
        cfg_block_err = 1'b0;
    endtask

    task automatic t_watchdog();
        cfg_level = 2'd3;
        cfg_wdog_en = 1'b0;
        push(8'h50, 3'b000);
        cyc(2);
        ticks(70);
        check("R5 disabled no irq", rx_irq, 0);
        pop_chk("R5 drain", 8'h50);
        cfg_wdog_en = 1'b1;
        push(8'h51, 3'b000);
        cyc(2);
        ticks(63);
        check("R4 not yet at 63", rx_irq, 0);
        ticks(1);
        check("R4 fires at 64", rx_irq, 1);
        push(8'h52, 3'b000);
        check("R5 write keeps fired", rx_irq, 1);
        pop_chk("R5 read", 8'h51);
        check("R5 read clears", rx_irq, 0);
        cyc(2);
        ticks(40);
        push(8'h53, 3'b000);
        ticks(40);
        check("R4 restarted by write", rx_irq, 0);
        ticks(23);
        check("R4 restart 63", rx_irq, 0);
        ticks(1);
        check("R4 restart 64", rx_irq, 1);
        cfg_wdog_en = 1'b0;
        cyc(1);
        check("R5 disable clears", rx_irq, 0);
        pop_chk("R4 drain a", 8'h52);
        pop_chk("R4 drain b", 8'h53);
        cfg_level = 2'd0;
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_order();
        t_levels();
        t_flow_overrun();
        t_same_cycle();
        t_err_modes();
        t_watchdog();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule